// File: doc/BRIEF.md
# Byte-Wide Serial Port Controller

This block is a small asynchronous serial port seen by a host through eight byte-wide registers on word-aligned addresses. The host reads and writes them through a single-cycle port: a select, a write strobe, an address, a write byte and a combinational read byte. Characters travel as 8N1 frames: one low start bit, eight data bits least significant first, one high stop bit. A 16-bit divisor sets the rate. The bit clock is four oversample ticks, and one tick lasts divisor+1 clock cycles.

On the transmit side there is one holding register that feeds a shift state machine. Its states are TX_IDLE, TX_START, TX_DATA and TX_STOP. A data write moves TX_IDLE to TX_START. Each end of a bit (four ticks) advances TX_START to TX_DATA, TX_DATA to TX_STOP after the eighth bit, and TX_STOP back to TX_IDLE.

The receiver runs on a two-stage synchronised line. Its states are RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_HOLD. A low line seen on a tick moves RX_IDLE to RX_START. A start bit that reads high at its middle sample goes back to RX_IDLE, and otherwise the end of the bit leads to RX_DATA. After eight bits it goes to RX_STOP. The stop sample goes to RX_IDLE if the line is high, or to RX_HOLD if it is low, and RX_HOLD goes back to RX_IDLE once the line is high. Received characters enter a four-entry FIFO. A status byte gathers the FIFO state, two sticky error flags and two interrupt enables, and one interrupt line merges the receive and transmit requests.

Top module: `serport_ctrl`

## Requirements
- R1: The register index is address bits [4:2]: 0..3 identification, 4 data, 5 status, 6 divisor low byte, 7 divisor high byte. The identification registers read 0x53, 0x50, 0x52 and 0x54 (index 0 to 3) and ignore writes. An access with address bits [1:0] not zero is ignored and reads 0x00.
- R2: Status bits: 0 frame error, 1 overrun, 2 receive interrupt enable, 3 receive FIFO full, 4 receive FIFO has exactly one free slot, 5 receive FIFO empty, 6 transmit interrupt enable, 7 transmitter empty. After reset the status reads 0xA0 and the line output is high.
- R3: A data write while the transmitter is empty sends one frame: start bit 0, eight data bits LSB first, stop bit 1. Each bit lasts four ticks, the first bit begins the cycle after the write, and the line is high when nothing is being sent.
- R4: Transmitter empty (status bit 7) drops the cycle after an accepted data write and returns when the stop bit ends. A data write while it is low is ignored.
- R5: Received characters are stored in a four-entry FIFO. A read of the data register returns the oldest character and removes it, so characters come out in arrival order.
- R6: Status bit 3 is set with four characters stored, bit 4 with exactly three, and bit 5 with none.
- R7: A character that completes while the FIFO is full sets the overrun flag and is dropped. The stored characters are kept.
- R8: A frame whose stop bit samples low sets the frame error flag and stores no character.
- R9: The error flags are sticky. Each is cleared only by a status write with that bit at 0. Bits 2 and 6 take the written value, and bits 3, 4, 5 and 7 ignore writes.
- R10: The interrupt output equals (bit 2 and not bit 5) or (bit 6 and bit 7).
- R11: The divisor is {high, low} and resets to 0x001A. One tick lasts divisor+1 cycles. Writing either divisor byte reloads the tick counter with the new divisor, and the registers read back as written.
- R12: A low pulse on the receive line that is high again at the middle sample of the start bit produces no character and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
The transmit line is compared every cycle against a behavioural model of the tick counter and frame timing. The model is driven with the patterns 0xA5, 0x00 and 0xFF, which separate bit order from stuck levels. It also sees a write made while the transmitter is busy, which shows whether that write is ignored, and a change of divisor, which shows whether the counter is reloaded at once. Receive is tried with single characters, with fills to three, four and five entries (the FIFO flags and the overrun drop), with a frame whose stop bit is low, and with a short glitch that separates start-bit rejection from false capture. The interrupt is checked with each enable on its own, which shows that the two request terms are kept apart.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int HOST_ADDR_W = 5;
    localparam int BYTE_W      = 8;

    typedef enum logic [2:0] {
        REG_ID0    = 3'd0,
        REG_ID1    = 3'd1,
        REG_ID2    = 3'd2,
        REG_ID3    = 3'd3,
        REG_DATA   = 3'd4,
        REG_STATUS = 3'd5,
        REG_DIVLO  = 3'd6,
        REG_DIVHI  = 3'd7
    } reg_sel_e;

    // status bit positions (decoded by host software)
    localparam int ST_FERR    = 0;
    localparam int ST_OVR     = 1;
    localparam int ST_RXIE    = 2;
    localparam int ST_RXFULL  = 3;
    localparam int ST_RXONE   = 4;
    localparam int ST_RXEMPTY = 5;
    localparam int ST_TXIE    = 6;
    localparam int ST_TXEMPTY = 7;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_HOLD  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/serport_baudgen.sv
module serport_baudgen #(
    parameter int              DIV_W     = 16,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'd26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    output logic [DIV_W-1:0] div_q,
    output logic             tick
);
    localparam int HI_W = DIV_W - 8;

    logic [DIV_W-1:0] div_d;
    logic [DIV_W-1:0] cnt_q;
    logic             load;

    always_comb begin
        div_d = div_q;
        if (wr_lo) div_d[7:0]       = wdata;
        if (wr_hi) div_d[DIV_W-1:8] = wdata[HI_W-1:0];
    end

    assign load = wr_lo | wr_hi;
    assign tick = (cnt_q == '0) && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_RESET;
            cnt_q <= DIV_RESET;
        end else begin
            div_q <= div_d;
            if (load)
                cnt_q <= div_d;
            else if (cnt_q == '0)
                cnt_q <= div_q;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/serport_tx.sv
module serport_tx
    import serport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              idle
);
    localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [SUB_W-1:0]  sub_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              bit_end;

    assign bit_end = tick && (sub_q == SUB_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load)    state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && (bit_q == BIT_LAST)) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            default:               state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            if (state_q == TX_IDLE)
                sub_q <= '0;
            else if (tick)
                sub_q <= bit_end ? '0 : sub_q + 1'b1;

            if (state_q == TX_IDLE && load)
                shift_q <= load_data;
            else if (state_q == TX_DATA && bit_end)
                shift_q <= shift_q >> 1;

            if (state_q != TX_DATA)
                bit_q <= '0;
            else if (bit_end)
                bit_q <= bit_q + 1'b1;
        end
    end

    always_comb begin
        txd  = 1'b1;
        idle = 1'b0;
        unique case (state_q)
            TX_IDLE:  idle = 1'b1;
            TX_START: txd  = 1'b0;
            TX_DATA:  txd  = shift_q[0];
            TX_STOP:  txd  = 1'b1;
            default:  idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/serport_rx.sv
module serport_rx
    import serport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              done,
    output logic              frame_err,
    output logic [DATA_W-1:0] data
);
    localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    rx_state_e              state_q, state_d;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    logic [SUB_W-1:0]       sub_q;
    logic [BIT_W-1:0]       bit_q;
    logic [DATA_W-1:0]      shift_q;
    logic                   mid, bit_end;

    assign rx_s    = sync_q[SYNC_STAGES-1];
    assign mid     = tick && (sub_q == SUB_MID);
    assign bit_end = tick && (sub_q == SUB_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !rx_s) state_d = RX_START;
            RX_START: begin
                if (mid && rx_s)  state_d = RX_IDLE;
                else if (bit_end) state_d = RX_DATA;
            end
            RX_DATA:  if (bit_end && (bit_q == BIT_LAST)) state_d = RX_STOP;
            RX_STOP:  if (mid) state_d = rx_s ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rx_s) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            if (state_q == RX_IDLE || state_q == RX_HOLD)
                sub_q <= '0;
            else if (tick)
                sub_q <= bit_end ? '0 : sub_q + 1'b1;

            if (state_q != RX_DATA)
                bit_q <= '0;
            else if (bit_end)
                bit_q <= bit_q + 1'b1;

            if (state_q == RX_DATA && mid)
                shift_q <= {rx_s, shift_q[DATA_W-1:1]};
        end
    end

    always_comb begin
        done      = 1'b0;
        frame_err = 1'b0;
        data      = shift_q;
        unique case (state_q)
            RX_STOP: begin
                done      = mid && rx_s;
                frame_err = mid && !rx_s;
            end
            RX_IDLE, RX_START, RX_DATA, RX_HOLD: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/serport_fifo.sv
module serport_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              one_free,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign full     = (count == CNT_FULL);
    assign one_free = (count == CNT_ONE);
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign rdata    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
    import serport_pkg::*;
#(
    parameter int          RX_DEPTH  = 4,
    parameter int          OSR       = 4,
    parameter int          DIV_W     = 16,
    parameter logic [15:0] DIV_RESET = 16'h001A,
    parameter logic [31:0] ID_VALUE  = 32'h5452_5053
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [HOST_ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0]      bus_wdata,
    output logic [BYTE_W-1:0]      bus_rdata,
    input  logic                   rxd,
    output logic                   txd,
    output logic                   irq
);
    reg_sel_e          reg_idx;
    logic              aligned, wr_hit, rd_hit, st_wr;
    logic              tick, tx_idle, tx_load;
    logic              rx_done, rx_ferr;
    logic [BYTE_W-1:0] rx_byte, fifo_head;
    logic              rx_full, rx_one, rx_empty;
    logic [DIV_W-1:0]  div_q;
    logic              err_frame_q, err_ovr_q, rx_ie_q, tx_ie_q;
    logic [BYTE_W-1:0] status;

    assign reg_idx = reg_sel_e'(bus_addr[4:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_sel && bus_wr && aligned;
    assign rd_hit  = bus_sel && !bus_wr && aligned;
    assign st_wr   = wr_hit && (reg_idx == REG_STATUS);
    assign tx_load = wr_hit && (reg_idx == REG_DATA) && tx_idle;

    serport_baudgen #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_hit && (reg_idx == REG_DIVLO)),
        .wr_hi (wr_hit && (reg_idx == REG_DIVHI)),
        .wdata (bus_wdata),
        .div_q (div_q),
        .tick  (tick)
    );

    serport_tx #(.DATA_W(BYTE_W), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (tx_load),
        .load_data (bus_wdata),
        .txd       (txd),
        .idle      (tx_idle)
    );

    serport_rx #(.DATA_W(BYTE_W), .OSR(OSR), .SYNC_STAGES(2)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .done      (rx_done),
        .frame_err (rx_ferr),
        .data      (rx_byte)
    );

    serport_fifo #(.DATA_W(BYTE_W), .DEPTH(RX_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_done),
        .wdata    (rx_byte),
        .pop      (rd_hit && (reg_idx == REG_DATA)),
        .rdata    (fifo_head),
        .full     (rx_full),
        .one_free (rx_one),
        .empty    (rx_empty)
    );

    // control and sticky error flags: a new event wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_frame_q <= 1'b0;
            err_ovr_q   <= 1'b0;
            rx_ie_q     <= 1'b0;
            tx_ie_q     <= 1'b0;
        end else begin
            if (rx_ferr)                             err_frame_q <= 1'b1;
            else if (st_wr && !bus_wdata[ST_FERR])   err_frame_q <= 1'b0;
            if (rx_done && rx_full)                  err_ovr_q   <= 1'b1;
            else if (st_wr && !bus_wdata[ST_OVR])    err_ovr_q   <= 1'b0;
            if (st_wr) begin
                rx_ie_q <= bus_wdata[ST_RXIE];
                tx_ie_q <= bus_wdata[ST_TXIE];
            end
        end
    end

    always_comb begin
        status              = '0;
        status[ST_FERR]     = err_frame_q;
        status[ST_OVR]      = err_ovr_q;
        status[ST_RXIE]     = rx_ie_q;
        status[ST_RXFULL]   = rx_full;
        status[ST_RXONE]    = rx_one;
        status[ST_RXEMPTY]  = rx_empty;
        status[ST_TXIE]     = tx_ie_q;
        status[ST_TXEMPTY]  = tx_idle;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (reg_idx)
                REG_ID0:    bus_rdata = ID_VALUE[7:0];
                REG_ID1:    bus_rdata = ID_VALUE[15:8];
                REG_ID2:    bus_rdata = ID_VALUE[23:16];
                REG_ID3:    bus_rdata = ID_VALUE[31:24];
                REG_DATA:   bus_rdata = rx_empty ? '0 : fifo_head;
                REG_STATUS: bus_rdata = status;
                REG_DIVLO:  bus_rdata = div_q[7:0];
                REG_DIVHI:  bus_rdata = div_q[15:8];
                default:    bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        irq = (rx_ie_q && !rx_empty) || (tx_ie_q && tx_idle);
    end
endmodule

// File: rtl/serport_ctrl_chk.sv
module serport_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [4:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       txd,
    input logic       irq,
    input logic       tx_idle,
    input logic       err_frame,
    input logic       err_ovr,
    input logic       rx_ie,
    input logic       tx_ie,
    input logic       fifo_full,
    input logic       fifo_one,
    input logic       fifo_empty
);
    logic st_wr, data_wr;
    assign st_wr   = bus_sel && bus_wr && (bus_addr == 5'h14);
    assign data_wr = bus_sel && bus_wr && (bus_addr == 5'h10);

    // R9: sticky flags hold unless cleared by a zero written to their bit
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr && !(st_wr && !bus_wdata[1])) |=> err_ovr);
    a_r9_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !(st_wr && !bus_wdata[0])) |=> err_frame);

    // R7: overrun only rises when the FIFO was full
    a_r7_ovr_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $past(fifo_full));

    // R6: FIFO level flags are mutually exclusive
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_full, fifo_one, fifo_empty}));

    // R4: transmitter leaves empty only after a data write
    a_r4_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_idle) |-> $past(data_wr));

    // R3: idle line is high
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    // R10: interrupt follows the enables
    a_r10_tx_request: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && tx_idle) |-> irq);
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);
endmodule

bind serport_ctrl serport_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .txd        (txd),
    .irq        (irq),
    .tx_idle    (tx_idle),
    .err_frame  (err_frame_q),
    .err_ovr    (err_ovr_q),
    .rx_ie      (rx_ie_q),
    .tx_ie      (tx_ie_q),
    .fifo_full  (rx_full),
    .fifo_one   (rx_one),
    .fifo_empty (rx_empty)
);

// File: tb/tb_serport_ctrl.sv
`timescale 1ns/1ps
module tb_serport_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;
    bit finished = 0;

    // behavioural reference state
    int        m_div = 26;
    int        m_cnt = 26;
    int        m_phase = -1;
    int        m_sub = 0;
    logic [7:0] m_byte = '0;
    bit        m_txie = 0;
    bit        m_rxie = 0;

    always #10 clk = ~clk;

    serport_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: tick counter and transmit frame timing
    always @(posedge clk) begin
        bit wr, ld, tk;
        int idx;
        if (!rst_n) begin
            m_div = 26; m_cnt = 26; m_phase = -1; m_sub = 0; m_txie = 0; m_rxie = 0;
        end else begin
            wr  = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
            idx = int'(bus_addr[4:2]);
            ld  = wr && (idx == 6 || idx == 7);
            tk  = (m_cnt == 0) && !ld;
            if (m_phase < 0) begin
                if (wr && idx == 4) begin m_phase = 0; m_sub = 0; m_byte = bus_wdata; end
            end else if (tk) begin
                if (m_sub == 3) begin
                    m_sub = 0; m_phase++;
                    if (m_phase == 10) m_phase = -1;
                end else m_sub++;
            end
            if (ld) begin
                if (idx == 6) m_div = (m_div & 32'hFF00) | int'(bus_wdata);
                else          m_div = (m_div & 32'h00FF) | (int'(bus_wdata) << 8);
                m_cnt = m_div;
            end else if (m_cnt == 0) m_cnt = m_div;
            else m_cnt--;
            if (wr && idx == 5) begin m_txie = bus_wdata[6]; m_rxie = bus_wdata[2]; end
        end
    end

    function automatic logic exp_txd();
        if (m_phase < 0 || m_phase == 9) return 1'b1;
        if (m_phase == 0) return 1'b0;
        return m_byte[m_phase-1];
    endfunction

    // per-cycle comparison, mid-cycle
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk("R3 txd per cycle", {31'b0, txd}, {31'b0, exp_txd()});
            if (!m_rxie)
                chk("R10 irq per cycle", {31'b0, irq}, {31'b0, (m_txie && m_phase < 0)});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_checks++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(a, d);
        chk(req, {24'b0, d}, {24'b0, exp});
    endtask

    task automatic wait_tx_idle();
        while (m_phase >= 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit stop_hi);
        int bit_clks;
        bit_clks = 4 * (m_div + 1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bit_clks) @(negedge clk);
        end
        rxd = stop_hi;
        repeat (bit_clks) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * bit_clks) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 reset state
        rd_chk("R2 status after reset", 5'h14, 8'hA0);
        chk("R2 txd after reset", {31'b0, txd}, 32'd1);
        chk("R10 irq after reset", {31'b0, irq}, 32'd0);

        // R1 identification, write ignored, misaligned ignored
        bus_write(5'h00, 8'hFF);
        rd_chk("R1 id0", 5'h00, 8'h53);
        rd_chk("R1 id1", 5'h04, 8'h50);
        rd_chk("R1 id2", 5'h08, 8'h52);
        rd_chk("R1 id3", 5'h0C, 8'h54);
        rd_chk("R1 misaligned read", 5'h15, 8'h00);
        bus_write(5'h15, 8'h44);
        rd_chk("R1 misaligned write ignored", 5'h14, 8'hA0);

        // R11 divisor reset, write and readback
        rd_chk("R11 div low reset", 5'h18, 8'h1A);
        bus_write(5'h1C, 8'h01);
        rd_chk("R11 div high", 5'h1C, 8'h01);
        bus_write(5'h1C, 8'h00);
        bus_write(5'h18, 8'h02);
        rd_chk("R11 div low", 5'h18, 8'h02);

        // R3/R4 transmit patterns
        bus_write(5'h10, 8'hA5);
        rd_chk("R4 tx empty low after write", 5'h14, 8'h20);
        bus_write(5'h10, 8'h3C);   // busy: ignored, per-cycle model keeps 0xA5
        wait_tx_idle();
        rd_chk("R4 tx empty after stop", 5'h14, 8'hA0);
        bus_write(5'h10, 8'h00);
        wait_tx_idle();
        bus_write(5'h10, 8'hFF);
        wait_tx_idle();

        // R10 transmit interrupt
        bus_write(5'h14, 8'h40);
        @(negedge clk); #5;
        chk("R10 tx irq", {31'b0, irq}, 32'd1);
        bus_write(5'h10, 8'h81);
        #5 chk("R10 tx irq off while busy", {31'b0, irq}, 32'd0);
        wait_tx_idle();
        chk("R10 tx irq back", {31'b0, irq}, 32'd1);
        bus_write(5'h14, 8'h00);

        // R5/R6 receive and FIFO flags
        send_rx(8'h11, 1);
        send_rx(8'h22, 1);
        rd_chk("R6 two stored", 5'h14, 8'h80);
        rd_chk("R5 first char", 5'h10, 8'h11);
        rd_chk("R5 second char", 5'h10, 8'h22);
        rd_chk("R6 empty again", 5'h14, 8'hA0);
        send_rx(8'h31, 1);
        send_rx(8'h42, 1);
        send_rx(8'h53, 1);
        rd_chk("R6 one slot left", 5'h14, 8'h90);
        send_rx(8'h64, 1);
        rd_chk("R6 full", 5'h14, 8'h88);

        // R7 overrun
        send_rx(8'h75, 1);
        rd_chk("R7 overrun flag", 5'h14, 8'h8A);
        rd_chk("R7 kept 0", 5'h10, 8'h31);
        rd_chk("R7 kept 1", 5'h10, 8'h42);
        rd_chk("R7 kept 2", 5'h10, 8'h53);
        rd_chk("R7 kept 3", 5'h10, 8'h64);
        rd_chk("R7 empty after drain", 5'h14, 8'hA2);

        // R9 sticky clear and ignored bits
        bus_write(5'h14, 8'h02);
        rd_chk("R9 overrun kept by 1", 5'h14, 8'hA2);
        bus_write(5'h14, 8'h00);
        rd_chk("R9 overrun cleared by 0", 5'h14, 8'hA0);
        bus_write(5'h14, 8'h18);
        rd_chk("R9 fifo bits ignore writes", 5'h14, 8'hA0);

        // R8 frame error
        send_rx(8'h5A, 0);
        rd_chk("R8 frame error, nothing stored", 5'h14, 8'hA1);
        bus_write(5'h14, 8'h01);
        rd_chk("R9 frame kept by 1", 5'h14, 8'hA1);
        bus_write(5'h14, 8'h00);
        rd_chk("R9 frame cleared", 5'h14, 8'hA0);

        // R12 short glitch
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd_chk("R12 glitch rejected", 5'h14, 8'hA0);

        // R10 receive interrupt
        bus_write(5'h14, 8'h04);
        #5 chk("R10 rx irq idle", {31'b0, irq}, 32'd0);
        send_rx(8'hC3, 1);
        #5 chk("R10 rx irq pending", {31'b0, irq}, 32'd1);
        rd_chk("R10 rx status", 5'h14, 8'h84);
        rd_chk("R5 irq char", 5'h10, 8'hC3);
        #5 chk("R10 rx irq cleared", {31'b0, irq}, 32'd0);
        bus_write(5'h14, 8'h00);

        // R11 rate change reloads counter; per-cycle model checks timing
        bus_write(5'h18, 8'h05);
        bus_write(5'h10, 8'h5A);
        wait_tx_idle();
        send_rx(8'h96, 1);
        rd_chk("R11 receive at new rate", 5'h10, 8'h96);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule